// File: doc/BRIEF.md
# Matching-Pursuit Maximum-Energy Column Selector

This block performs the column-selection step of one orthogonal matching pursuit iteration. Another unit computes the residual's projection onto each dictionary column. That unit streams the projections into this block as a sweep of candidates, one per accepted cycle. Each candidate is a column of complex values with signed real and imaginary parts.

For every candidate the block forms an energy, which is the sum of the squared magnitudes of the column's entries. It keeps the running maximum while it skips any column already chosen in an earlier iteration. When the last candidate of the sweep has been taken in, the block appends the winning index to a support list. That list persists from one iteration to the next. The block also compares a residual-energy value supplied by the caller against a programmable threshold and raises a stop flag that tells the controller to end the pursuit.

A sweep begins with a start pulse. If the start pulse carries the fresh flag, it also empties the support list, which is how a new pursuit begins. The caller then presents the candidates in index order, beginning at index 0. The outputs are updated together in the cycle that follows the final candidate.

Top module: `omp_column_picker`

## Requirements
- R1: The energy of a candidate is the sum of re*re + im*im over all ROWS entries, computed without loss. The inputs are signed SAMPLE_W-bit values, and each entry's real part sits at bits [r*SAMPLE_W +: SAMPLE_W] of the real vector, with the imaginary part at the same slice of the imaginary vector. The winner's energy is reported on `win_energy_o`.
- R2: Candidates are numbered 0 to COLS-1 in order of acceptance after a start. `win_idx_o` reports the index of the eligible candidate with the largest energy, and it holds its value between done pulses.
- R3: When energies are equal, the lower index wins, because a later candidate replaces the running maximum only if its energy is strictly larger.
- R4: A candidate whose index is already one of the first `support_len_o` entries of the support list is excluded from the maximum search.
- R5: `done_o` is a single-cycle pulse that is high in the cycle after the COLS-th accepted candidate. A start pulse discards any candidate presented in the same cycle. Candidates presented while no sweep is running are ignored.
- R6: At each done, the winner is written into support entry `support_len_o`, located at bits [i*IDX_W +: IDX_W] of `support_o`, and the length rises by one. The list persists across sweeps. A start with `fresh_i` high sets the length to 0.
- R7: The length saturates at MAX_SUPPORT. A sweep that ends with a full list appends nothing, and any done that leaves the list full also sets `stop_o`.
- R8: At each done, `stop_o` is set to 1 if `resid_energy_i` is strictly less than `thresh_i`, both sampled with the final candidate, or if the list is full. It holds that value until the next done.
- R9: After reset, `done_o`, `stop_o`, `support_len_o`, `win_idx_o` and `win_energy_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a sweep and clears the running maximum |
| fresh_i | input | 1 | Sampled with start_i; empties the support list |
| cand_valid_i | input | 1 | A candidate column is present |
| cand_re_i | input | ROWS*SAMPLE_W | Real parts of the column entries |
| cand_im_i | input | ROWS*SAMPLE_W | Imaginary parts of the column entries |
| resid_energy_i | input | ENERGY_W | Residual energy used by the stop test |
| thresh_i | input | ENERGY_W | Stop threshold |
| done_o | output | 1 | Sweep-complete pulse |
| win_idx_o | output | IDX_W | Index of the selected column |
| win_energy_o | output | ENERGY_W | Energy of the selected column |
| support_o | output | MAX_SUPPORT*IDX_W | Support list, entry i at bits [i*IDX_W +: IDX_W] |
| support_len_o | output | LEN_W | Number of valid support entries |
| stop_o | output | 1 | Pursuit should stop |

## Verification
The bound checker watches several properties on every cycle. It confirms that done lasts one cycle and that the length never exceeds its bound. It confirms that the length changes only on a done (by one) or on a fresh start, and that a full list at done forces stop. It also confirms that the winner and stop outputs stay steady between done pulses. The remaining properties need a reference model, so only the directed scenarios can show them. These are the exact energy arithmetic, including the most negative input, the choice of the maximum, the lower-index rule on ties, the exclusion of indices already chosen, the strict comparison against the threshold, and the fact that idle candidates have no effect.

// File: rtl/omp_sel_pkg.sv
package omp_sel_pkg;

    localparam int DEF_ROWS        = 12;
    localparam int DEF_COLS        = 101;
    localparam int DEF_SAMPLE_W    = 18;
    localparam int DEF_MAX_SUPPORT = 12;

    // Bits needed to hold the sum of ROWS squared complex magnitudes:
    // each square of a signed value fits 2*w-1 bits, the re+im pair adds one,
    // and the row sum adds ceil(log2(rows)); one spare bit is kept.
    function automatic int energy_bits(input int sample_w, input int rows);
        return 2 * sample_w + $clog2(rows) + 1;
    endfunction

endpackage

// File: rtl/omp_energy_calc.sv
module omp_energy_calc #(
    parameter int ROWS     = 12,
    parameter int SAMPLE_W = 18,
    parameter int ENERGY_W = 41
) (
    input  logic [ROWS*SAMPLE_W-1:0] re_i,
    input  logic [ROWS*SAMPLE_W-1:0] im_i,
    output logic [ENERGY_W-1:0]      energy_o
);
    localparam int SQ_W  = 2 * SAMPLE_W;
    localparam int PAD_W = ENERGY_W - SQ_W;

    logic [ENERGY_W-1:0] row_mag [ROWS];

    for (genvar g = 0; g < ROWS; g++) begin : g_row
        logic signed [SAMPLE_W-1:0] re_s;
        logic signed [SAMPLE_W-1:0] im_s;
        logic signed [SQ_W-1:0]     re_sq;
        logic signed [SQ_W-1:0]     im_sq;
        assign re_s  = re_i[g*SAMPLE_W +: SAMPLE_W];
        assign im_s  = im_i[g*SAMPLE_W +: SAMPLE_W];
        assign re_sq = re_s * re_s;
        assign im_sq = im_s * im_s;
        // squares are never negative, so zero extension is exact
        assign row_mag[g] = {{PAD_W{1'b0}}, re_sq} + {{PAD_W{1'b0}}, im_sq};
    end

    always_comb begin
        energy_o = '0;
        for (int r = 0; r < ROWS; r++) begin
            energy_o = energy_o + row_mag[r];
        end
    end

endmodule

// File: rtl/omp_support_mask.sv
module omp_support_mask #(
    parameter int MAX_SUPPORT = 12,
    parameter int IDX_W       = 7,
    parameter int LEN_W       = 4
) (
    input  logic [IDX_W-1:0]             cand_idx_i,
    input  logic [MAX_SUPPORT*IDX_W-1:0] support_i,
    input  logic [LEN_W-1:0]             len_i,
    output logic                         hit_o
);
    logic [MAX_SUPPORT-1:0] match;

    for (genvar g = 0; g < MAX_SUPPORT; g++) begin : g_slot
        assign match[g] = (LEN_W'(g) < len_i) &&
                          (support_i[g*IDX_W +: IDX_W] == cand_idx_i);
    end

    assign hit_o = |match;

endmodule

// File: rtl/omp_max_step.sv
module omp_max_step #(
    parameter int IDX_W    = 7,
    parameter int ENERGY_W = 41
) (
    input  logic                eligible_i,
    input  logic [ENERGY_W-1:0] cand_en_i,
    input  logic                best_ok_i,
    input  logic [ENERGY_W-1:0] best_en_i,
    input  logic [IDX_W-1:0]    cand_idx_i,
    input  logic [IDX_W-1:0]    best_idx_i,
    output logic                take_o,
    output logic                fin_ok_o,
    output logic [IDX_W-1:0]    fin_idx_o,
    output logic [ENERGY_W-1:0] fin_en_o
);
    // strict comparison: an equal energy keeps the earlier index
    assign take_o    = eligible_i && (!best_ok_i || (cand_en_i > best_en_i));
    assign fin_ok_o  = best_ok_i || take_o;
    assign fin_idx_o = take_o ? cand_idx_i : best_idx_i;
    assign fin_en_o  = take_o ? cand_en_i  : best_en_i;

endmodule

// File: rtl/omp_column_picker.sv
module omp_column_picker #(
    parameter int ROWS        = omp_sel_pkg::DEF_ROWS,
    parameter int COLS        = omp_sel_pkg::DEF_COLS,
    parameter int SAMPLE_W    = omp_sel_pkg::DEF_SAMPLE_W,
    parameter int MAX_SUPPORT = omp_sel_pkg::DEF_MAX_SUPPORT,
    localparam int IDX_W      = $clog2(COLS),
    localparam int ENERGY_W   = omp_sel_pkg::energy_bits(SAMPLE_W, ROWS),
    localparam int LEN_W      = $clog2(MAX_SUPPORT + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_i,
    input  logic                         fresh_i,
    input  logic                         cand_valid_i,
    input  logic [ROWS*SAMPLE_W-1:0]     cand_re_i,
    input  logic [ROWS*SAMPLE_W-1:0]     cand_im_i,
    input  logic [ENERGY_W-1:0]          resid_energy_i,
    input  logic [ENERGY_W-1:0]          thresh_i,
    output logic                         done_o,
    output logic [IDX_W-1:0]             win_idx_o,
    output logic [ENERGY_W-1:0]          win_energy_o,
    output logic [MAX_SUPPORT*IDX_W-1:0] support_o,
    output logic [LEN_W-1:0]             support_len_o,
    output logic                         stop_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(COLS - 1);
    localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(MAX_SUPPORT);

    typedef struct packed {
        logic                                  busy;
        logic [IDX_W-1:0]                      cnt;
        logic                                  best_ok;
        logic [IDX_W-1:0]                      best_idx;
        logic [ENERGY_W-1:0]                   best_en;
        logic                                  done;
        logic [IDX_W-1:0]                      win_idx;
        logic [ENERGY_W-1:0]                   win_en;
        logic [MAX_SUPPORT-1:0][IDX_W-1:0]     sup;
        logic [LEN_W-1:0]                      len;
        logic                                  stop;
    } picker_state_t;

    picker_state_t st_q, st_d;

    logic [ENERGY_W-1:0] cand_en;
    logic                in_support;
    logic                accept;
    logic                last;
    logic                take;
    logic                fin_ok;
    logic [IDX_W-1:0]    fin_idx;
    logic [ENERGY_W-1:0] fin_en;

    omp_energy_calc #(
        .ROWS     (ROWS),
        .SAMPLE_W (SAMPLE_W),
        .ENERGY_W (ENERGY_W)
    ) u_energy (
        .re_i     (cand_re_i),
        .im_i     (cand_im_i),
        .energy_o (cand_en)
    );

    omp_support_mask #(
        .MAX_SUPPORT (MAX_SUPPORT),
        .IDX_W       (IDX_W),
        .LEN_W       (LEN_W)
    ) u_mask (
        .cand_idx_i (st_q.cnt),
        .support_i  (st_q.sup),
        .len_i      (st_q.len),
        .hit_o      (in_support)
    );

    assign accept = st_q.busy && cand_valid_i && !start_i;
    assign last   = accept && (st_q.cnt == LAST_IDX);

    omp_max_step #(
        .IDX_W    (IDX_W),
        .ENERGY_W (ENERGY_W)
    ) u_step (
        .eligible_i (accept && !in_support),
        .cand_en_i  (cand_en),
        .best_ok_i  (st_q.best_ok),
        .best_en_i  (st_q.best_en),
        .cand_idx_i (st_q.cnt),
        .best_idx_i (st_q.best_idx),
        .take_o     (take),
        .fin_ok_o   (fin_ok),
        .fin_idx_o  (fin_idx),
        .fin_en_o   (fin_en)
    );

    always_comb begin
        logic [LEN_W-1:0] new_len;
        st_d      = st_q;
        st_d.done = 1'b0;
        new_len   = st_q.len;
        if (start_i) begin
            st_d.busy     = 1'b1;
            st_d.cnt      = '0;
            st_d.best_ok  = 1'b0;
            st_d.best_idx = '0;
            st_d.best_en  = '0;
            if (fresh_i) begin
                st_d.len = '0;
                st_d.sup = '0;
            end
        end else if (accept) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (take) begin
                st_d.best_ok  = 1'b1;
                st_d.best_idx = st_q.cnt;
                st_d.best_en  = cand_en;
            end
            if (last) begin
                st_d.busy    = 1'b0;
                st_d.done    = 1'b1;
                st_d.win_idx = fin_idx;
                st_d.win_en  = fin_en;
                if (fin_ok && (st_q.len < FULL_LEN)) begin
                    st_d.sup[st_q.len] = fin_idx;
                    new_len            = st_q.len + 1'b1;
                end
                st_d.len  = new_len;
                st_d.stop = (resid_energy_i < thresh_i) || (new_len == FULL_LEN);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o        = st_q.done;
    assign win_idx_o     = st_q.win_idx;
    assign win_energy_o  = st_q.win_en;
    assign support_o     = st_q.sup;
    assign support_len_o = st_q.len;
    assign stop_o        = st_q.stop;

endmodule

// File: rtl/omp_column_picker_chk.sv
module omp_column_picker_chk #(
    parameter int ROWS        = 12,
    parameter int COLS        = 101,
    parameter int SAMPLE_W    = 18,
    parameter int MAX_SUPPORT = 12,
    localparam int IDX_W      = $clog2(COLS),
    localparam int ENERGY_W   = omp_sel_pkg::energy_bits(SAMPLE_W, ROWS),
    localparam int LEN_W      = $clog2(MAX_SUPPORT + 1)
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         start_i,
    input logic                         fresh_i,
    input logic                         cand_valid_i,
    input logic [ROWS*SAMPLE_W-1:0]     cand_re_i,
    input logic [ROWS*SAMPLE_W-1:0]     cand_im_i,
    input logic [ENERGY_W-1:0]          resid_energy_i,
    input logic [ENERGY_W-1:0]          thresh_i,
    input logic                         done_o,
    input logic [IDX_W-1:0]             win_idx_o,
    input logic [ENERGY_W-1:0]          win_energy_o,
    input logic [MAX_SUPPORT*IDX_W-1:0] support_o,
    input logic [LEN_W-1:0]             support_len_o,
    input logic                         stop_o
);
    localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(MAX_SUPPORT);

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7
    len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        support_len_o <= FULL_LEN);

    // R7
    full_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (support_len_o == FULL_LEN)) |-> stop_o);

    // R6
    len_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((support_len_o != $past(support_len_o)) && !$past(start_i && fresh_i))
            |-> (done_o && (support_len_o == $past(support_len_o) + 1'b1)));

    // R2
    win_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(win_idx_o) && $stable(win_energy_o)));

    // R8
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(stop_o));

endmodule

bind omp_column_picker omp_column_picker_chk #(
    .ROWS        (ROWS),
    .COLS        (COLS),
    .SAMPLE_W    (SAMPLE_W),
    .MAX_SUPPORT (MAX_SUPPORT)
) u_chk (.*);

// File: tb/omp_column_picker_test.sv
module omp_column_picker_test;
    localparam int ROWS     = 12;
    localparam int COLS     = 101;
    localparam int SW       = 18;
    localparam int MAXS     = 12;
    localparam int IDX_W    = $clog2(COLS);
    localparam int EW       = 2 * SW + $clog2(ROWS) + 1;
    localparam int LEN_W    = $clog2(MAXS + 1);

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  start_i = 1'b0;
    logic                  fresh_i = 1'b0;
    logic                  cand_valid_i = 1'b0;
    logic [ROWS*SW-1:0]    cand_re_i = '0;
    logic [ROWS*SW-1:0]    cand_im_i = '0;
    logic [EW-1:0]         resid_energy_i = '0;
    logic [EW-1:0]         thresh_i = '0;
    logic                  done_o;
    logic [IDX_W-1:0]      win_idx_o;
    logic [EW-1:0]         win_energy_o;
    logic [MAXS*IDX_W-1:0] support_o;
    logic [LEN_W-1:0]      support_len_o;
    logic                  stop_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int exp_sup [MAXS];
    int exp_len = 0;

    always #2 clk = ~clk;

    omp_column_picker uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start_i),
        .fresh_i        (fresh_i),
        .cand_valid_i   (cand_valid_i),
        .cand_re_i      (cand_re_i),
        .cand_im_i      (cand_im_i),
        .resid_energy_i (resid_energy_i),
        .thresh_i       (thresh_i),
        .done_o         (done_o),
        .win_idx_o      (win_idx_o),
        .win_energy_o   (win_energy_o),
        .support_o      (support_o),
        .support_len_o  (support_len_o),
        .stop_o         (stop_o)
    );

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int sample_val(input int pat, input int k,
                                      input int r, input bit im);
        case (pat)
            0:       return ((k * 37 + r * 11 + (im ? 5 : 0)) % 200 - 100) * 600;
            1:       return 1000;
            2:       return (k == 50) ? 30000 : ((k == 70) ? 20000 : 100);
            default: return -131072;
        endcase
    endfunction

    function automatic longint col_energy(input int pat, input int k);
        longint acc = 0;
        for (int r = 0; r < ROWS; r++) begin
            longint a = sample_val(pat, k, r, 1'b0);
            longint b = sample_val(pat, k, r, 1'b1);
            acc += a * a + b * b;
        end
        return acc;
    endfunction

    task automatic drive_col(input int pat, input int k);
        for (int r = 0; r < ROWS; r++) begin
            cand_re_i[r*SW +: SW] = SW'(sample_val(pat, k, r, 1'b0));
            cand_im_i[r*SW +: SW] = SW'(sample_val(pat, k, r, 1'b1));
        end
    endtask

    // one full sweep, with a model of the expected selection
    task automatic run_sweep(input string req, input int pat, input bit fresh,
                             input longint resid, input longint thr);
        bit     ok = 0;
        int     best = 0;
        longint best_en = 0;
        bit     exp_stop;
        if (fresh) exp_len = 0;
        for (int k = 0; k < COLS; k++) begin
            bit masked = 0;
            longint e = col_energy(pat, k);
            for (int j = 0; j < exp_len; j++) if (exp_sup[j] == k) masked = 1;
            if (!masked && (!ok || e > best_en)) begin
                ok = 1; best = k; best_en = e;
            end
        end
        if (exp_len < MAXS) begin
            exp_sup[exp_len] = best;
            exp_len++;
        end
        exp_stop = (resid < thr) || (exp_len == MAXS);

        resid_energy_i = EW'(resid);
        thresh_i       = EW'(thr);
        @(negedge clk);
        start_i = 1'b1; fresh_i = fresh;
        @(negedge clk);
        start_i = 1'b0; fresh_i = 1'b0;
        for (int k = 0; k < COLS; k++) begin
            cand_valid_i = 1'b1;
            drive_col(pat, k);
            if (k < COLS - 1) begin
                @(negedge clk);
                check(req, "done early", longint'(done_o), 0);
            end else begin
                @(negedge clk);
            end
        end
        cand_valid_i = 1'b0;
        check({req, " R5"}, "done pulse", longint'(done_o), 1);
        check({req, " R2"}, "winner index", longint'(win_idx_o), best);
        check({req, " R1"}, "winner energy", longint'(win_energy_o), best_en);
        check({req, " R6"}, "support length", longint'(support_len_o), exp_len);
        for (int j = 0; j < exp_len; j++)
            check({req, " R6"}, "support entry",
                  longint'(support_o[j*IDX_W +: IDX_W]), exp_sup[j]);
        check({req, " R8"}, "stop flag", longint'(stop_o), longint'(exp_stop));
        @(negedge clk);
        check("R5", "done after pulse", longint'(done_o), 0);
    endtask

    task automatic test_reset();
        check("R9", "reset done", longint'(done_o), 0);
        check("R9", "reset stop", longint'(stop_o), 0);
        check("R9", "reset length", longint'(support_len_o), 0);
        check("R9", "reset index", longint'(win_idx_o), 0);
        check("R9", "reset energy", longint'(win_energy_o), 0);
    endtask

    task automatic test_mixed();
        run_sweep("R1", 0, 1'b1, 1000, 10);
        run_sweep("R2", 0, 1'b0, 1000, 10);
    endtask

    task automatic test_tie();
        // all equal: lowest index, then the next unmasked one
        run_sweep("R3", 1, 1'b1, 1000, 10);
        check("R3", "tie winner", longint'(win_idx_o), 0);
        run_sweep("R4", 1, 1'b0, 1000, 10);
        check("R4", "masked tie winner", longint'(win_idx_o), 1);
    endtask

    task automatic test_mask();
        run_sweep("R4", 2, 1'b1, 1000, 10);
        check("R4", "peak chosen", longint'(win_idx_o), 50);
        run_sweep("R4", 2, 1'b0, 1000, 10);
        check("R4", "peak masked", longint'(win_idx_o), 70);
    endtask

    task automatic test_extreme();
        run_sweep("R1", 3, 1'b1, 1000, 10);
        check("R1", "extreme energy", longint'(win_energy_o),
              longint'(ROWS) * 2 * 131072 * 131072);
    endtask

    task automatic test_idle();
        logic [LEN_W-1:0] len0 = support_len_o;
        logic [IDX_W-1:0] idx0 = win_idx_o;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            cand_valid_i = 1'b1;
            drive_col(2, c);
        end
        @(negedge clk);
        cand_valid_i = 1'b0;
        check("R5", "idle no done", longint'(done_o), 0);
        @(negedge clk);
        check("R5", "idle no done later", longint'(done_o), 0);
        check("R5", "idle length kept", longint'(support_len_o), longint'(len0));
        check("R5", "idle index kept", longint'(win_idx_o), longint'(idx0));
    endtask

    task automatic test_stop();
        run_sweep("R8", 0, 1'b1, 100, 101);
        check("R8", "below threshold stops", longint'(stop_o), 1);
        run_sweep("R8", 0, 1'b0, 101, 101);
        check("R8", "equal threshold runs", longint'(stop_o), 0);
    endtask

    task automatic test_full();
        for (int s = 0; s < MAXS; s++) run_sweep("R7", 1, (s == 0), 1000, 10);
        check("R7", "full length", longint'(support_len_o), MAXS);
        check("R7", "full stop", longint'(stop_o), 1);
        run_sweep("R7", 1, 1'b0, 1000, 10);
        check("R7", "saturated length", longint'(support_len_o), MAXS);
        check("R7", "saturated stop", longint'(stop_o), 1);
        run_sweep("R6", 1, 1'b1, 1000, 10);
        check("R6", "fresh restart length", longint'(support_len_o), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_mixed();
        test_tie();
        test_mask();
        test_extreme();
        test_idle();
        test_stop();
        test_full();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule